// File: doc/BRIEF.md
# CAN Controller Control and Interrupt Unit

This block holds the control byte of a CAN protocol controller and turns the protocol engine's event strobes into interrupt requests. A CPU writes and reads the control byte and reads an interrupt register through a small register port. The control byte holds four interrupt enables, a resynchronization-mode bit for the bit-timing logic, and the reset request. The engine reports five kinds of event: receive done without errors, transmit done, transmit buffer released after an abort, a change of error or bus status, and overrun. An event sets its own pending flag only when its enable is set. The interrupt request is the OR of all pending flags.

The block also runs the reset request. While the request is set, the block holds the protocol engine in reset, which aborts any frame in progress. The request can be raised in three ways: by the external asynchronous reset, by a CPU write, or by the controller itself (for example on bus-off). Only a CPU write can clear it. Once it is cleared, the engine stays in reset until the bus has been seen recessive for 11 consecutive sample points. If the controller raised the request itself, it needs `SELF_RUNS` such runs of 11 instead.

Top module: `canctl_top`

## Requirements
- R1: When the overrun enable (control bit 4) is 1, an `ev_overrun` pulse sets pending bit 3 on the next clock. When the enable is 0, the pulse leaves pending bit 3 clear.
- R2: When the error enable (control bit 3) is 1, an `ev_err_change` pulse sets pending bit 2 on the next clock.
- R3: When the transmit enable (control bit 2) is 1, either `ev_tx_done` or `ev_tx_released` sets pending bit 1 on the next clock.
- R4: When the receive enable (control bit 1) is 1, `ev_rx_ok` sets pending bit 0 on the next clock. No other input sets that bit.
- R5: While the reset request (control bit 0) is 1, `engine_reset` is 1.
- R6: The reset request is set by the external reset, by a CPU control write that sets bit 0 while the request is 0, or by `self_reset_req`. It is cleared only by a CPU control write with bit 0 equal to 0 while the request is 1.
- R7: After a request raised by the CPU or by the external reset is cleared, `engine_reset` falls on the clock edge that samples the 11th consecutive `sample_strobe` with `bus_rx`=1. A strobe with `bus_rx`=0 restarts the count.
- R8: After a request raised by `self_reset_req` is cleared, `engine_reset` falls only after `SELF_RUNS` completed runs of 11 recessive strobes.
- R9: `resync_mode` follows control bit 6. Value 0 selects resynchronization on recessive-to-dominant edges only.
- R10: The external reset (`rst_n` low, asynchronous) makes the control byte read 0x01 and clears all pending flags.
- R11: `irq` is the OR of `irq_pending`. A CPU read of address 1 returns the pending flags in bits 3:0 and clears them on that edge. An event in the same cycle as the read still sets its flag.
- R12: A control write (address 0) whose bit 0 differs from the current request changes only the request. Any other control write updates the enables (bits 4:1) and the mode (bit 6) and leaves the request unchanged. The control byte reads back with bits 5 and 7 equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | External asynchronous reset, active low |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_addr | input | 1 | 0 = control byte, 1 = interrupt register |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, combinational on `cpu_addr` |
| ev_overrun | input | 1 | Overrun status set |
| ev_err_change | input | 1 | Error or bus status changed |
| ev_tx_done | input | 1 | Message transmitted successfully |
| ev_tx_released | input | 1 | Transmit buffer accessible after abort |
| ev_rx_ok | input | 1 | Message received without errors |
| self_reset_req | input | 1 | Controller raises its own reset request |
| sample_strobe | input | 1 | One pulse per bit sample point |
| bus_rx | input | 1 | Sampled bus level, 1 = recessive |
| engine_reset | output | 1 | Holds the protocol engine in reset |
| resync_mode | output | 1 | Resynchronization mode select |
| irq | output | 1 | Interrupt request |
| irq_pending | output | 4 | Pending flags: 3 overrun, 2 error, 1 transmit, 0 receive |

## Verification
The properties assume the event inputs and `sample_strobe` are synchronous single-cycle pulses. They also assume `bus_rx` matters only in a cycle where a strobe is present. They assume `self_reset_req` never shares a cycle with a CPU control write, because the write rule and the self-raise would otherwise compete for the request bit. The stimulus drives every input just after a falling edge, holds each pulse for one cycle, and keeps `self_reset_req` out of any cycle that carries a control write. Recessive and dominant samples are mixed so that the run counter restarts before it completes a run.

// File: rtl/canctl_pkg.sv
package canctl_pkg;
  localparam int BIT_RQ   = 0;
  localparam int BIT_EN_LO = 1;
  localparam int BIT_EN_HI = 4;
  localparam int BIT_MODE = 6;
  localparam int NUM_SRC  = 4;

  typedef enum logic { SRC_HOST = 1'b0, SRC_SELF = 1'b1 } rq_src_e;

  function automatic logic [7:0] pack_ctrl(input logic rq, input logic [NUM_SRC-1:0] en,
                                           input logic mode);
    logic [7:0] b;
    b = 8'h00;
    b[BIT_RQ] = rq;
    b[BIT_EN_HI:BIT_EN_LO] = en;
    b[BIT_MODE] = mode;
    return b;
  endfunction

  function automatic logic next_pending(input logic cur, input logic clr,
                                        input logic ev, input logic en);
    return (cur & ~clr) | (ev & en);
  endfunction
endpackage

// File: rtl/canctl_ctrl_reg.sv
module canctl_ctrl_reg
  import canctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_ctrl,
  input  logic [7:0]         wdata,
  input  logic               self_req,
  output logic               rq_q,
  output rq_src_e            src_q,
  output logic [NUM_SRC-1:0] en_q,
  output logic               mode_q,
  output logic               rq_write
);
  assign rq_write = wr_ctrl & (wdata[BIT_RQ] != rq_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rq_q   <= 1'b1;
      src_q  <= SRC_HOST;
      en_q   <= '0;
      mode_q <= 1'b0;
    end else begin
      if (rq_write) begin
        rq_q <= wdata[BIT_RQ];
        if (wdata[BIT_RQ]) src_q <= SRC_HOST;
      end else if (wr_ctrl) begin
        en_q   <= wdata[BIT_EN_HI:BIT_EN_LO];
        mode_q <= wdata[BIT_MODE];
      end
      if (self_req) begin
        rq_q  <= 1'b1;
        src_q <= SRC_SELF;
      end
    end
  end
endmodule

// File: rtl/canctl_irq.sv
module canctl_irq
  import canctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] ev,
  input  logic [NUM_SRC-1:0] en,
  input  logic               rd_clr,
  output logic [NUM_SRC-1:0] pend_q,
  output logic               irq
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[i] <= 1'b0;
      else        pend_q[i] <= next_pending(pend_q[i], rd_clr, ev[i], en[i]);
    end
  end

  assign irq = |pend_q;
endmodule

// File: rtl/canctl_release.sv
module canctl_release
  import canctl_pkg::*;
#(
  parameter int RUN_BITS  = 11,
  parameter int SELF_RUNS = 128
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    rq,
  input  rq_src_e src,
  input  logic    strobe,
  input  logic    bus_rx,
  output logic    hold_q,
  output logic    run_hit,
  output logic    release_now
);
  localparam int CW = $clog2(RUN_BITS + 1);
  localparam int RW = $clog2(SELF_RUNS + 1);

  logic [CW-1:0] cnt_q;
  logic [RW-1:0] runs_q;
  logic          last_run;

  assign run_hit     = hold_q & ~rq & strobe & bus_rx & (cnt_q == CW'(RUN_BITS - 1));
  assign last_run    = (src == SRC_HOST) | (runs_q == RW'(SELF_RUNS - 1));
  assign release_now = run_hit & last_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b1;
      cnt_q  <= '0;
      runs_q <= '0;
    end else if (rq) begin
      hold_q <= 1'b1;
      cnt_q  <= '0;
      runs_q <= '0;
    end else if (hold_q && strobe) begin
      if (!bus_rx) begin
        cnt_q <= '0;
      end else if (run_hit) begin
        cnt_q  <= '0;
        runs_q <= runs_q + 1'b1;
        if (last_run) hold_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/canctl_top.sv
module canctl_top
  import canctl_pkg::*;
#(
  parameter int RUN_BITS  = 11,
  parameter int SELF_RUNS = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_wr,
  input  logic       cpu_rd,
  input  logic       cpu_addr,
  input  logic [7:0] cpu_wdata,
  output logic [7:0] cpu_rdata,
  input  logic       ev_overrun,
  input  logic       ev_err_change,
  input  logic       ev_tx_done,
  input  logic       ev_tx_released,
  input  logic       ev_rx_ok,
  input  logic       self_reset_req,
  input  logic       sample_strobe,
  input  logic       bus_rx,
  output logic       engine_reset,
  output logic       resync_mode,
  output logic       irq,
  output logic [3:0] irq_pending
);
  logic               rq_q;
  rq_src_e            src_q;
  logic [NUM_SRC-1:0] en_q;
  logic               mode_q;
  logic               rq_write;
  logic               hold_q;
  logic               run_hit;
  logic               release_now;
  logic [NUM_SRC-1:0] ev_vec;
  logic               rd_clr;

  assign ev_vec = {ev_overrun, ev_err_change, ev_tx_done | ev_tx_released, ev_rx_ok};
  assign rd_clr = cpu_rd & cpu_addr;

  canctl_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(cpu_wr & ~cpu_addr), .wdata(cpu_wdata),
    .self_req(self_reset_req), .rq_q(rq_q), .src_q(src_q), .en_q(en_q),
    .mode_q(mode_q), .rq_write(rq_write)
  );

  canctl_irq u_irq (
    .clk(clk), .rst_n(rst_n), .ev(ev_vec), .en(en_q), .rd_clr(rd_clr),
    .pend_q(irq_pending), .irq(irq)
  );

  canctl_release #(.RUN_BITS(RUN_BITS), .SELF_RUNS(SELF_RUNS)) u_rel (
    .clk(clk), .rst_n(rst_n), .rq(rq_q), .src(src_q), .strobe(sample_strobe),
    .bus_rx(bus_rx), .hold_q(hold_q), .run_hit(run_hit), .release_now(release_now)
  );

  assign engine_reset = rq_q | hold_q;
  assign resync_mode  = mode_q;
  assign cpu_rdata    = cpu_addr ? {4'b0000, irq_pending} : pack_ctrl(rq_q, en_q, mode_q);
endmodule

// File: rtl/canctl_chk.sv
module canctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_wr,
  input logic       cpu_rd,
  input logic       cpu_addr,
  input logic [7:0] cpu_wdata,
  input logic       ev_overrun,
  input logic       ev_err_change,
  input logic       ev_tx_done,
  input logic       ev_tx_released,
  input logic       ev_rx_ok,
  input logic       sample_strobe,
  input logic       bus_rx,
  input logic       engine_reset,
  input logic [3:0] irq_pending,
  input logic       rq,
  input logic [3:0] en,
  input logic       mode,
  input logic       release_now
);
  logic any_ev;
  assign any_ev = ev_overrun | ev_err_change | ev_tx_done | ev_tx_released | ev_rx_ok;

  AST_OVR_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overrun && en[3] |=> irq_pending[3]); // R1
  AST_ERR_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err_change && en[2] |=> irq_pending[2]); // R2
  AST_TX_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tx_done || ev_tx_released) && en[1] |=> irq_pending[1]); // R3
  AST_RX_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_ok && en[0] |=> irq_pending[0]); // R4
  AST_RQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    rq |=> engine_reset); // R5
  AST_RQ_CPU_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rq) |-> $past(cpu_wr && !cpu_addr && !cpu_wdata[0])); // R6
  AST_RELEASE_RECESSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(engine_reset) |-> $past(sample_strobe && bus_rx && !rq)); // R7
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd && cpu_addr && !any_ev |=> irq_pending == 4'b0000); // R11
  AST_RQ_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && !cpu_addr && (cpu_wdata[0] != rq) |=> $stable(en) && $stable(mode)); // R12
  AST_RELEASE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    release_now |=> !engine_reset); // R8
endmodule

bind canctl_top canctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
  .cpu_wdata(cpu_wdata), .ev_overrun(ev_overrun), .ev_err_change(ev_err_change),
  .ev_tx_done(ev_tx_done), .ev_tx_released(ev_tx_released), .ev_rx_ok(ev_rx_ok),
  .sample_strobe(sample_strobe), .bus_rx(bus_rx), .engine_reset(engine_reset),
  .irq_pending(irq_pending), .rq(rq_q), .en(en_q), .mode(mode_q),
  .release_now(release_now)
);

// File: tb/canctl_top_test.sv
`timescale 1ns/1ps
module canctl_top_test;
  localparam int SELF_N = 128;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_wr = 0, cpu_rd = 0, cpu_addr = 0;
  logic [7:0] cpu_wdata = 8'h00;
  logic ev_overrun = 0, ev_err_change = 0, ev_tx_done = 0, ev_tx_released = 0, ev_rx_ok = 0;
  logic self_reset_req = 0, sample_strobe = 0, bus_rx = 1;
  logic [7:0] cpu_rdata;
  logic engine_reset, resync_mode, irq;
  logic [3:0] irq_pending;

  int tests = 0, fails = 0, cycles = 0;
  bit started = 0;

  canctl_top uut (.*);

  always #2 clk = ~clk;

  // behavioural reference
  bit m_rq, m_self, m_hold, m_mode;
  bit [3:0] m_en, m_pend;
  int m_cnt, m_runs;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rq = 1; m_self = 0; m_hold = 1; m_mode = 0; m_en = 0; m_pend = 0; m_cnt = 0; m_runs = 0;
    end else begin
      bit [3:0] evs;
      bit old_rq;
      old_rq = m_rq;
      evs = {ev_overrun, ev_err_change, ev_tx_done || ev_tx_released, ev_rx_ok};
      if (cpu_rd && cpu_addr) m_pend = 0;
      m_pend = m_pend | (evs & m_en);
      if (cpu_wr && !cpu_addr) begin
        if (cpu_wdata[0] != m_rq) begin
          m_rq = cpu_wdata[0];
          if (m_rq) m_self = 0;
        end else begin
          m_en = cpu_wdata[4:1]; m_mode = cpu_wdata[6];
        end
      end
      if (self_reset_req) begin m_rq = 1; m_self = 1; end
      if (old_rq) begin
        m_hold = 1; m_cnt = 0; m_runs = 0;
      end else if (m_hold && sample_strobe) begin
        if (!bus_rx) m_cnt = 0;
        else begin
          m_cnt++;
          if (m_cnt == 11) begin
            m_cnt = 0; m_runs++;
            if (!m_self || m_runs == SELF_N) m_hold = 0;
          end
        end
      end
    end
  end

  function automatic bit [7:0] m_rdata(input bit a);
    if (a) return {4'b0, m_pend};
    return {1'b0, m_mode, 1'b0, m_en, m_rq};
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (started && rst_n) begin
      check("R5 R7 R8 engine_reset model", engine_reset, m_rq || m_hold);
      check("R1 R2 R3 R4 pending model", irq_pending, m_pend);
      check("R11 irq model", irq, |m_pend);
      check("R9 resync model", resync_mode, m_mode);
      check("R12 rdata model", cpu_rdata, m_rdata(cpu_addr));
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<=150000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic step(); @(negedge clk); #1; endtask

  task automatic wr_ctrl(input bit [7:0] d);
    step(); cpu_wr = 1; cpu_addr = 0; cpu_wdata = d;
    step(); cpu_wr = 0;
  endtask

  task automatic rd_ctrl(output bit [7:0] v);
    step(); cpu_addr = 0; #0.5 v = cpu_rdata;
  endtask

  task automatic rd_irq(output bit [7:0] v);
    step(); cpu_addr = 1; cpu_rd = 1; #0.5 v = cpu_rdata;
    step(); cpu_rd = 0; cpu_addr = 0;
  endtask

  task automatic pulse(input int which);
    step();
    case (which)
      0: ev_rx_ok = 1; 1: ev_tx_done = 1; 2: ev_tx_released = 1;
      3: ev_err_change = 1; 4: ev_overrun = 1; default: self_reset_req = 1;
    endcase
    step();
    {ev_rx_ok, ev_tx_done, ev_tx_released, ev_err_change, ev_overrun, self_reset_req} = '0;
  endtask

  task automatic strobe(input bit rec);
    step(); sample_strobe = 1; bus_rx = rec;
    step(); sample_strobe = 0; bus_rx = 1;
  endtask

  initial begin
    bit [7:0] v;
    #5 rst_n = 1; started = 1;
    rd_ctrl(v); check("R10 reset ctrl byte", v, 8'h01);
    check("R10 reset pending", irq_pending, 0);
    check("R5 engine held at reset", engine_reset, 1);

    wr_ctrl(8'h5F); rd_ctrl(v);
    check("R12 enables written, rq kept", v, 8'h5F);
    check("R9 resync mode 1", resync_mode, 1);
    wr_ctrl(8'h00); rd_ctrl(v);
    check("R12 rq cleared, enables kept", v, 8'h5E);
    check("R6 CPU clears request", v[0], 0);

    for (int i = 0; i < 5; i++) strobe(1);
    strobe(0);
    for (int i = 0; i < 10; i++) strobe(1);
    check("R7 still held after 10 recessive", engine_reset, 1);
    strobe(1);
    check("R7 released after 11th recessive", engine_reset, 0);

    pulse(4); check("R1 overrun pending", irq_pending[3], 1);
    check("R11 irq set", irq, 1);
    pulse(3); check("R2 error pending", irq_pending[2], 1);
    pulse(0); check("R4 receive pending", irq_pending[0], 1);
    rd_irq(v); check("R11 read value", v, 8'h0D);
    check("R11 cleared by read", irq_pending, 0);
    pulse(2); check("R3 tx released pending", irq_pending[1], 1);
    rd_irq(v);
    pulse(1); check("R3 tx done pending", irq_pending[1], 1);
    rd_irq(v);

    wr_ctrl(8'h00); check("R9 resync mode 0", resync_mode, 0);
    for (int k = 0; k < 5; k++) pulse(k);
    check("R1 disabled overrun ignored", irq_pending[3], 0);
    check("R4 disabled events ignored", irq_pending, 0);
    check("R11 no irq when disabled", irq, 0);

    pulse(5); rd_ctrl(v);
    check("R6 self raise sets request", v[0], 1);
    check("R5 held on self request", engine_reset, 1);
    wr_ctrl(8'h00);
    for (int r = 0; r < SELF_N - 1; r++)
      for (int i = 0; i < 11; i++) strobe(1);
    check("R8 held before last run", engine_reset, 1);
    for (int i = 0; i < 11; i++) strobe(1);
    check("R8 released after all runs", engine_reset, 0);

    wr_ctrl(8'h01); rd_ctrl(v); check("R6 CPU sets request", v, 8'h01);
    for (int i = 0; i < 12; i++) strobe(1);
    check("R6 request not cleared by bus", engine_reset, 1);
    wr_ctrl(8'h00);
    for (int i = 0; i < 11; i++) strobe(1);
    check("R7 CPU-raised release", engine_reset, 0);

    wr_ctrl(8'h1E); pulse(0);
    #1 rst_n = 0; #0.5;
    check("R10 async ctrl byte", cpu_rdata, 8'h01);
    check("R10 async pending clear", irq_pending, 0);
    step(); rst_n = 1;

    for (int c = 0; c < 4000; c++) begin
      step();
      cpu_wr = ($urandom % 8) == 0; cpu_rd = ($urandom % 6) == 0;
      cpu_addr = $urandom % 2; cpu_wdata = $urandom;
      if (cpu_wr && !cpu_addr && cpu_wdata[0] && ($urandom % 4) != 0) cpu_wdata[0] = 0;
      {ev_rx_ok, ev_tx_done, ev_tx_released, ev_err_change, ev_overrun} = $urandom & $urandom;
      self_reset_req = !(cpu_wr && !cpu_addr) && ($urandom % 300) == 0;
      sample_strobe = ($urandom % 2); bus_rx = ($urandom % 10) != 0;
    end
    step();
    {cpu_wr, cpu_rd, ev_rx_ok, ev_tx_done, ev_tx_released, ev_err_change, ev_overrun,
     self_reset_req, sample_strobe} = '0;
    step();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule